// File: doc/BRIEF.md
# Dirty Band Update Tracker

This block walks a frame as a sequence of four-line bands, one band per clock. Each band maps to one page of the 8-bit pixel plane. For the band under scan, the tracker puts the band index on `scan_band`, and the dirty-flag storage outside the block answers in the same cycle. Runs of adjacent dirty bands are merged into full-width update rectangles. Each rectangle is handed to a display sink through a valid/ready pair.

Across the frame the block records the lowest and highest dirty page. When the scan ends, it issues one clear command over that range. The command goes out only if some page was dirty.

In wide-colour mode, a band also counts as dirty when any of the four matching pages of the 24-bit plane or the control plane is dirty. In that mode the clear command also carries the matching page range for those planes, which is four times larger. Pixel copying and the flag memory are outside this block.

Top module: `band_dirty_tracker`

## Requirements
- R1: Band k covers lines 4k to 4k+3. For a frame of H lines, bands 0 to ceil(H/4)-1 are scanned in order, one per clock while not stalled. With `rect_ready` held high, `busy` stays high for ceil(H/4)+1 cycles after the start is accepted.
- R2: A dirty band found while no run is open starts a run at line 4k of that band.
- R3: A clean band at index k that follows an open run closes the run and emits a rectangle. The rectangle starts at x 0, has `rect_y` equal to the run start and `rect_w` equal to the frame width latched at start, and has `rect_h` = 4k - run start. Every emitted height is a nonzero multiple of 4.
- R4: A run still open when the scan ends is emitted with `rect_h` = 4*ceil(H/4) - run start. This holds when H is not a multiple of 4.
- R5: At the end of the scan, `clr_valid` pulses high for exactly one cycle, with `clr_lo` and `clr_hi` set to the lowest and highest dirty band index, where `clr_lo` <= `clr_hi`. If no band was dirty, no pulse is given.
- R6: With `mode24` = 0 at start, only `pg8_dirty` decides whether a band is dirty. `pg24_dirty` and `pgc_dirty` have no effect.
- R7: With `mode24` = 1 at start, a band is dirty if `pg8_dirty` is set or if any bit of `pg24_dirty` or `pgc_dirty` is set.
- R8: With a clear issued in wide-colour mode, `clr_wide_en` = 1 and the wide range runs from page 4*`clr_lo` to 4*`clr_hi`+3 inclusive. In 8-bit mode, `clr_wide_en` = 0.
- R9: While `rect_valid` is high and `rect_ready` is low, the rectangle fields stay stable and the scan does not advance.
- R10: A `frame_start` pulse while `busy` is high is ignored. The current scan continues without restarting.
- R11: After reset, `busy`, `rect_valid` and `clr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a scan when idle |
| mode24 | input | 1 | Wide-colour mode, latched at start |
| frame_height | input | LINE_W | Frame height in lines, latched at start |
| frame_width | input | WIDTH_W | Frame width in pixels, latched at start |
| scan_band | output | LINE_W-2 | Index of the band being examined |
| pg8_dirty | input | 1 | Dirty flag of the 8-bit page for `scan_band` |
| pg24_dirty | input | 4 | Dirty flags of the four 24-bit pages for `scan_band` |
| pgc_dirty | input | 4 | Dirty flags of the four control pages for `scan_band` |
| busy | output | 1 | Scan in progress |
| rect_valid | output | 1 | Rectangle descriptor valid |
| rect_ready | input | 1 | Sink accepts the rectangle |
| rect_y | output | LINE_W | First line of the rectangle |
| rect_h | output | LINE_W+1 | Rectangle height in lines |
| rect_w | output | WIDTH_W | Rectangle width in pixels |
| clr_valid | output | 1 | One-cycle clear command |
| clr_lo | output | LINE_W-2 | Lowest dirty 8-bit page |
| clr_hi | output | LINE_W-2 | Highest dirty 8-bit page |
| clr_wide_en | output | 1 | Wide-plane ranges also to be cleared |
| clr_wide_lo | output | LINE_W | First 24-bit and control page to clear |
| clr_wide_hi | output | LINE_W | Last 24-bit and control page to clear |

## Verification
The in-line properties check on every cycle that:
- a stalled rectangle holds its fields and freezes the scan;
- the band counter only holds or steps by one while busy, so a mid-scan start pulse cannot rewind it;
- the clear strobe lasts one cycle with an ordered range;
- every rectangle height is a positive multiple of four.

Which bands merge into which rectangles, and the final run flush, can only be shown by the bench's frame scenarios. The same goes for the ignored wide flags in 8-bit mode, the wide-colour merge and the absence of a clear on a clean frame. Each scenario compares the rectangles and clears against a model of the band walk.

// File: rtl/band_dirty_tracker.sv
module band_dirty_tracker #(
  parameter int LINE_W  = 10,
  parameter int WIDTH_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 mode24,
  input  logic [LINE_W-1:0]    frame_height,
  input  logic [WIDTH_W-1:0]   frame_width,
  output logic [LINE_W-3:0]    scan_band,
  input  logic                 pg8_dirty,
  input  logic [3:0]           pg24_dirty,
  input  logic [3:0]           pgc_dirty,
  output logic                 busy,
  output logic                 rect_valid,
  input  logic                 rect_ready,
  output logic [LINE_W-1:0]    rect_y,
  output logic [LINE_W:0]      rect_h,
  output logic [WIDTH_W-1:0]   rect_w,
  output logic                 clr_valid,
  output logic [LINE_W-3:0]    clr_lo,
  output logic [LINE_W-3:0]    clr_hi,
  output logic                 clr_wide_en,
  output logic [LINE_W-1:0]    clr_wide_lo,
  output logic [LINE_W-1:0]    clr_wide_hi
);
  localparam int BAND_W = LINE_W - 2;

  logic [BAND_W:0]      band;
  logic [LINE_W-1:0]    h_lat;
  logic [WIDTH_W-1:0]   w_lat;
  logic                 wide, run_open, any_dirty;
  logic [BAND_W-1:0]    run_start, pg_min, pg_max;

  wire [LINE_W:0]   cur_y      = {band, 2'b00};
  wire [LINE_W:0]   start_y    = {1'b0, run_start, 2'b00};
  wire              stall      = rect_valid & ~rect_ready;
  wire              at_end     = cur_y >= {1'b0, h_lat};
  wire              band_dirty = pg8_dirty | (wide & ((|pg24_dirty) | (|pgc_dirty)));
  wire [BAND_W-1:0] cur_pg     = band[BAND_W-1:0];

  assign scan_band   = cur_pg;
  assign clr_wide_lo = {clr_lo, 2'b00};
  assign clr_wide_hi = {clr_hi, 2'b11};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      band        <= '0;
      h_lat       <= '0;
      w_lat       <= '0;
      wide        <= 1'b0;
      run_open    <= 1'b0;
      any_dirty   <= 1'b0;
      run_start   <= '0;
      pg_min      <= '1;
      pg_max      <= '0;
      rect_valid  <= 1'b0;
      rect_y      <= '0;
      rect_h      <= '0;
      rect_w      <= '0;
      clr_valid   <= 1'b0;
      clr_lo      <= '0;
      clr_hi      <= '0;
      clr_wide_en <= 1'b0;
    end else begin
      clr_valid <= 1'b0;
      if (rect_valid && rect_ready) rect_valid <= 1'b0;
      if (!busy) begin
        if (frame_start) begin
          busy      <= 1'b1;
          band      <= '0;
          h_lat     <= frame_height;
          w_lat     <= frame_width;
          wide      <= mode24;
          run_open  <= 1'b0;
          any_dirty <= 1'b0;
          pg_min    <= '1;
          pg_max    <= '0;
        end
      end else if (!stall) begin
        if (at_end) begin
          busy <= 1'b0;
          if (run_open) begin
            rect_valid <= 1'b1;
            rect_y     <= start_y[LINE_W-1:0];
            rect_h     <= cur_y - start_y;
            rect_w     <= w_lat;
            run_open   <= 1'b0;
          end
          if (any_dirty) begin
            clr_valid   <= 1'b1;
            clr_lo      <= pg_min;
            clr_hi      <= pg_max;
            clr_wide_en <= wide;
          end
        end else begin
          band <= band + 1'b1;
          if (band_dirty) begin
            any_dirty <= 1'b1;
            if (!run_open) begin
              run_open  <= 1'b1;
              run_start <= cur_pg;
            end
            if (cur_pg < pg_min) pg_min <= cur_pg;
            if (cur_pg > pg_max) pg_max <= cur_pg;
          end else if (run_open) begin
            rect_valid <= 1'b1;
            rect_y     <= start_y[LINE_W-1:0];
            rect_h     <= cur_y - start_y;
            rect_w     <= w_lat;
            run_open   <= 1'b0;
          end
        end
      end
    end
  end

  a_r9_rect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h) && $stable(rect_w));

  a_r9_scan_pause: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rect_valid && !rect_ready |=> $stable(band));

  a_r10_no_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (band == $past(band)) || (band == (BAND_W+1)'($past(band) + 1'b1)));

  a_r5_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !clr_valid);

  a_r5_clr_order: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_lo <= clr_hi);

  a_r3_rect_height: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> (rect_h != '0) && (rect_h[1:0] == 2'b00));
endmodule

// File: tb/band_dirty_tracker_test.sv
module band_dirty_tracker_test;
  localparam int LW = 10;
  localparam int WW = 11;

  logic clk = 0, rst_n = 0, frame_start = 0, mode24 = 0;
  logic [LW-1:0] frame_height = '0;
  logic [WW-1:0] frame_width = '0;
  logic [LW-3:0] scan_band;
  logic pg8_dirty;
  logic [3:0] pg24_dirty, pgc_dirty;
  logic busy, rect_valid, rect_ready = 1, clr_valid, clr_wide_en;
  logic [LW-1:0] rect_y, clr_wide_lo, clr_wide_hi;
  logic [LW:0] rect_h;
  logic [WW-1:0] rect_w;
  logic [LW-3:0] clr_lo, clr_hi;

  always #2.5 clk = ~clk;

  band_dirty_tracker #(.LINE_W(LW), .WIDTH_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode24(mode24),
    .frame_height(frame_height), .frame_width(frame_width), .scan_band(scan_band),
    .pg8_dirty(pg8_dirty), .pg24_dirty(pg24_dirty), .pgc_dirty(pgc_dirty),
    .busy(busy), .rect_valid(rect_valid), .rect_ready(rect_ready),
    .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w), .clr_valid(clr_valid),
    .clr_lo(clr_lo), .clr_hi(clr_hi), .clr_wide_en(clr_wide_en),
    .clr_wide_lo(clr_wide_lo), .clr_wide_hi(clr_wide_hi));

  logic       d8 [256];
  logic [3:0] d24[256];
  logic [3:0] dc [256];
  always_comb begin
    pg8_dirty  = d8[scan_band];
    pg24_dirty = d24[scan_band];
    pgc_dirty  = dc[scan_band];
  end

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R3";
  logic [39:0] exp_rect[$];
  logic [40:0] exp_clr[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  int stall_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (stall_mode == 0) rect_ready = 1;
    else if (stall_mode == 1) rect_ready = lfsr[0];
    else rect_ready = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (rect_valid && rect_ready) begin
      if (exp_rect.size() == 0)
        check(0, tag, "unexpected rect_y", rect_y, -1);
      else begin
        logic [39:0] e;
        e = exp_rect.pop_front();
        check(rect_y == e[39:30], tag, "rect_y", rect_y, e[39:30]);
        check(rect_h == e[29:19], tag, "rect_h", rect_h, e[29:19]);
        check(rect_w == e[18:8],  tag, "rect_w", rect_w, e[18:8]);
      end
    end
    if (clr_valid) begin
      if (exp_clr.size() == 0)
        check(0, "R5", "unexpected clr_lo", clr_lo, -1);
      else begin
        logic [40:0] c;
        c = exp_clr.pop_front();
        check(clr_lo == c[40:33], "R5", "clr_lo", clr_lo, c[40:33]);
        check(clr_hi == c[32:25], "R5", "clr_hi", clr_hi, c[32:25]);
        check(clr_wide_en == c[24], "R8", "clr_wide_en", clr_wide_en, c[24]);
        if (c[24]) begin
          check(clr_wide_lo == 10'(c[40:33]) * 4, "R8", "clr_wide_lo", clr_wide_lo, c[40:33] * 4);
          check(clr_wide_hi == 10'(c[32:25]) * 4 + 3, "R8", "clr_wide_hi", clr_wide_hi, c[32:25] * 4 + 3);
        end
      end
    end
  end

  task automatic clear_map();
    for (int i = 0; i < 256; i++) begin d8[i] = 0; d24[i] = 0; dc[i] = 0; end
  endtask

  task automatic model(input int h, input int w, input bit m);
    int nb, st, lo, hi;
    bit open, any;
    nb = (h + 3) / 4; open = 0; any = 0; lo = 255; hi = 0; st = 0;
    for (int b = 0; b < nb; b++) begin
      bit dty;
      dty = d8[b] | (m & ((|d24[b]) | (|dc[b])));
      if (dty) begin
        any = 1;
        if (!open) begin open = 1; st = b * 4; end
        if (b < lo) lo = b;
        if (b > hi) hi = b;
      end else if (open) begin
        exp_rect.push_back({10'(st), 11'(b * 4 - st), 11'(w), 8'd0});
        open = 0;
      end
    end
    if (open) exp_rect.push_back({10'(st), 11'(nb * 4 - st), 11'(w), 8'd0});
    if (any) exp_clr.push_back({8'(lo), 8'(hi), m, 24'd0});
  endtask

  task automatic start(input int h, input int w, input bit m);
    model(h, w, m);
    @(negedge clk);
    frame_height = LW'(h); frame_width = WW'(w); mode24 = m; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic wait_done(input string req);
    while (busy || rect_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_rect.size() == 0, req, "rects left over", exp_rect.size(), 0);
    check(exp_clr.size() == 0, "R5", "clears left over", exp_clr.size(), 0);
  endtask

  initial begin
    clear_map();
    repeat (3) @(negedge clk);
    check(busy == 0, "R11", "busy after reset", busy, 0);
    check(rect_valid == 0, "R11", "rect_valid after reset", rect_valid, 0);
    check(clr_valid == 0, "R11", "clr_valid after reset", clr_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R5: 8-bit frame, bands 1,2,5 dirty
    tag = "R3";
    d8[1] = 1; d8[2] = 1; d8[5] = 1;
    begin
      int busy_cnt;
      busy_cnt = 0;
      start(32, 640, 0);
      busy_cnt = 1;
      while (busy) begin @(negedge clk); if (busy) busy_cnt++; end
      check(busy_cnt == 9, "R1", "busy cycles", busy_cnt, 9);
    end
    wait_done("R2");

    // R6: wide flags set on clean bands are ignored in 8-bit mode
    tag = "R6";
    d24[0] = 4'b0100; dc[7] = 4'b0001; dc[3] = 4'b1000;
    start(32, 800, 0);
    wait_done("R6");

    // R7 R8 R4: same map in wide-colour mode
    tag = "R7";
    start(32, 1024, 1);
    wait_done("R7");

    // R5: clean frame, no rect and no clear
    tag = "R5";
    clear_map();
    start(40, 320, 1);
    wait_done("R5");

    // R4: height not multiple of 4, run open to the end
    tag = "R4";
    d8[0] = 1; d8[1] = 1; d8[2] = 1;
    start(10, 100, 0);
    wait_done("R4");

    // R9: sink holds ready low
    tag = "R9";
    clear_map();
    d8[1] = 1;
    stall_mode = 2;
    start(32, 512, 0);
    while (!rect_valid) @(negedge clk);
    begin
      logic [LW-3:0] sb;
      logic [LW-1:0] ry;
      sb = scan_band; ry = rect_y;
      repeat (4) @(negedge clk);
      check(scan_band == sb, "R9", "scan_band during stall", scan_band, sb);
      check(rect_y == ry, "R9", "rect_y during stall", rect_y, ry);
      check(busy == 1, "R9", "busy during stall", busy, 1);
    end
    stall_mode = 0;
    wait_done("R9");

    // R10 R9: random stalls, mid-scan restart pulse ignored
    tag = "R10";
    clear_map();
    for (int i = 0; i < 32; i++) begin
      d8[i] = (i % 5 == 1) || (i % 5 == 2);
      d24[i] = (i % 7 == 4) ? 4'b0010 : 4'b0000;
    end
    stall_mode = 1;
    start(128, 1024, 1);
    repeat (6) @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    @(negedge clk);
    check(busy == 1 && scan_band >= 3, "R10", "scan_band after mid-scan start", scan_band, 3);
    wait_done("R10");
    stall_mode = 0;

    finish_run();
  end
endmodule